// File: doc/BRIEF.md
# Multi-source port pin output logic

This block drives one bidirectional pin of a small microcontroller port. Three sources can set the level on the pin. The first is a software data bit. The second is the level bit of a timer compare unit. The third is the output of an analog comparator, and it counts only when a separate option enable allows it. The three sources are combined with an OR. The result reaches the pad only while the pin's direction bit marks it as an output.

Software reaches the block through a simple register bus with an address, a write strobe, a read strobe and write and read data buses. Three registers are mapped on this bus:
- a data register;
- a direction register;
- a write-only pulldown-inhibit register.

Each register holds one bit, at a fixed bit lane of the byte. The block also controls the pad's pulldown device. It turns the pulldown off whenever the pin is an output. While the pin is an input, it leaves the pulldown on unless software has inhibited it.

Top module: `pin_mux_port`

## Requirements
- R1: After reset, the data, direction and pulldown-inhibit bits are all 0. The outputs are then `pin_oe`=0, `pin_out`=0 and `pulldown_en`=1.
- R2: While `pin_oe` is 1, `pin_out` equals data bit OR `cmp_level` OR (`comp_out` AND `comp_opt_en`). While `pin_oe` is 0, `pin_out` is 0.
- R3: While `comp_opt_en` is 0, `comp_out` has no effect on `pin_out`.
- R4: `pin_oe` equals the direction bit. A write to address 0x05 loads that bit from `wdata[4]`. The new value shows on `pin_oe` in the cycle after the clock edge that samples the write strobe.
- R5: `pulldown_en` is 1 exactly when the direction bit is 0 and the pulldown-inhibit bit is 0. It is therefore never 1 while `pin_oe` is 1.
- R6: A write to address 0x01 loads the data bit from `wdata[4]`. When the direction bit is 1, a read of 0x01 returns that bit in `rdata[4]`, with all other bits 0.
- R7: When the direction bit is 0, a read of 0x01 returns the `pin_in` level in `rdata[4]`, with all other bits 0.
- R8: A read of 0x05 returns the direction bit in `rdata[4]`, with all other bits 0.
- R9: A write to address 0x11 loads the pulldown-inhibit bit from `wdata[4]`. A read of 0x11 returns 0.
- R10: A read of any address other than 0x01 and 0x05 returns 0. A write to any address other than 0x01, 0x05 and 0x11 changes no register.
- R11: While `rd_en` is 0, `rdata` is 0.
- R12: Only bit 4 of `wdata` is used. The other write data bits have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| cmp_level | input | 1 | Level bit from the timer compare unit |
| comp_out | input | 1 | Analog comparator output |
| comp_opt_en | input | 1 | Lets the comparator reach the pin |
| pin_in | input | 1 | Sampled pad input level |
| pin_out | output | 1 | Value driven onto the pad |
| pin_oe | output | 1 | Pad output enable |
| pulldown_en | output | 1 | Pad pulldown enable |

## Verification
The assertions check several rules on every cycle:
- the pulldown and the output enable are never on together;
- an undriven pin stays low;
- a high compare level, or an enabled high comparator, forces the pin high;
- idle and unmapped reads return zero;
- a direction write appears on the output enable one cycle later.

The bench sweeps every combination of the three register bits and the four side inputs. This shows the full OR function, the gating of the comparator and the readback that depends on direction. The bench also writes all ones to every unmapped address and checks the readback afterwards. Only these scenarios can show that such writes leave every register untouched.

// File: rtl/pin_mux_port.sv
module pin_mux_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int BIT = 4,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h01,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 'h05,
  parameter logic [ADDR_W-1:0] PD_ADDR = 'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              cmp_level,
  input  logic              comp_out,
  input  logic              comp_opt_en,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              pulldown_en
);
  logic data_q, dir_q, pd_inh_q;
  logic rd_bit, rd_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= 1'b0;
      dir_q    <= 1'b0;
      pd_inh_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == DATA_ADDR) data_q   <= wdata[BIT];
      if (addr == DIR_ADDR)  dir_q    <= wdata[BIT];
      if (addr == PD_ADDR)   pd_inh_q <= wdata[BIT];
    end
  end

  assign pin_oe      = dir_q;
  assign pin_out     = dir_q & (data_q | cmp_level | (comp_out & comp_opt_en));
  assign pulldown_en = ~dir_q & ~pd_inh_q;

  always_comb begin
    rd_hit = 1'b0;
    rd_bit = 1'b0;
    if (addr == DATA_ADDR) begin
      rd_hit = 1'b1;
      rd_bit = dir_q ? data_q : pin_in;
    end else if (addr == DIR_ADDR) begin
      rd_hit = 1'b1;
      rd_bit = dir_q;
    end
    rdata = '0;
    if (rd_en && rd_hit) rdata[BIT] = rd_bit;
  end
endmodule

module pin_mux_port_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int BIT = 4,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h01,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 'h05
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              cmp_level,
  input logic              comp_out,
  input logic              comp_opt_en,
  input logic              pin_out,
  input logic              pin_oe,
  input logic              pulldown_en
);
  assert_oe_from_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == DIR_ADDR) |=> (pin_oe == $past(wdata[BIT])));

  assert_no_pull_on_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> !pulldown_en);

  assert_quiet_when_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_out);

  assert_level_forces_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && cmp_level) |-> pin_out);

  assert_comp_enabled_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && comp_opt_en && comp_out) |-> pin_out);

  assert_unmapped_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr != DATA_ADDR && addr != DIR_ADDR) |-> (rdata == '0));

  assert_idle_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));
endmodule

bind pin_mux_port pin_mux_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT(BIT),
  .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .cmp_level(cmp_level), .comp_out(comp_out),
  .comp_opt_en(comp_opt_en), .pin_out(pin_out), .pin_oe(pin_oe),
  .pulldown_en(pulldown_en)
);

// File: tb/test_pin_mux_port.sv
`timescale 1ns/1ps
module test_pin_mux_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       cmp_level = 1'b0, comp_out = 1'b0, comp_opt_en = 1'b0, pin_in = 1'b0;
  logic       pin_out, pin_oe, pulldown_en;
  int         n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  pin_mux_port i_pin_mux_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .cmp_level(cmp_level), .comp_out(comp_out),
    .comp_opt_en(comp_opt_en), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pulldown_en(pulldown_en)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
    #1;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    check("R1 oe", {7'b0, pin_oe}, 8'h00);
    check("R1 out", {7'b0, pin_out}, 8'h00);
    check("R1 pulldown", {7'b0, pulldown_en}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle rdata", rdata, 8'h00);
    rd(8'h05, r); check("R1 dir read", r, 8'h00);

    for (int v = 0; v < 128; v++) begin
      logic d, dir, pdi, cl, co, opt, pi;
      logic exp_out;
      {d, dir, pdi, cl, co, opt, pi} = v[6:0];
      wr(8'h01, d ? 8'hEF | 8'h10 : 8'hEF);
      wr(8'h05, {3'b0, dir, 4'b0});
      wr(8'h11, {3'b0, pdi, 4'b0} | 8'h0F);
      cmp_level = cl; comp_out = co; comp_opt_en = opt; pin_in = pi;
      #1;
      exp_out = dir & (d | cl | (co & opt));
      check(opt ? "R2 out" : "R3 out gated", {7'b0, pin_out}, {7'b0, exp_out});
      check("R4 oe", {7'b0, pin_oe}, {7'b0, dir});
      check("R5 pulldown", {7'b0, pulldown_en}, {7'b0, ~dir & ~pdi});
      rd(8'h01, r);
      check(dir ? "R6 data read" : "R7 pin read", r, {3'b0, dir ? d : pi, 4'b0});
      rd(8'h05, r); check("R8 dir read", r, {3'b0, dir, 4'b0});
      rd(8'h11, r); check("R9 pd read zero", r, 8'h00);
    end
    cmp_level = 0; comp_out = 0; comp_opt_en = 0; pin_in = 0;

    wr(8'h01, 8'h10); wr(8'h05, 8'h00); wr(8'h11, 8'h00);
    for (int a = 0; a < 256; a++) begin
      if (a != 8'h01 && a != 8'h05 && a != 8'h11) begin
        wr(a[7:0], 8'hFF);
        rd(a[7:0], r); check("R10 unmapped read", r, 8'h00);
      end
    end
    check("R10 oe kept", {7'b0, pin_oe}, 8'h00);
    check("R10 pulldown kept", {7'b0, pulldown_en}, 8'h01);
    wr(8'h05, 8'h10);
    rd(8'h01, r); check("R10 data kept", r, 8'h10);
    check("R12 out from data", {7'b0, pin_out}, 8'h01);
    wr(8'h01, 8'hEF);
    check("R12 other bits ignored", {7'b0, pin_out}, 8'h00);
    wr(8'h05, 8'hEF);
    check("R12 dir other bits", {7'b0, pin_oe}, 8'h00);
    @(negedge clk);
    check("R11 idle end", rdata, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule